// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This unit runs register-to-register shift and rotate operations on a 32-bit data word, moving it by one bit position on each clock. It carries out logical and arithmetic shifts in both directions, plain rotates in both directions, and rotates that pass through a separate extend bit. The operand can be a byte, a word or a long word. For the narrower sizes, only the low bits of the register take part.

The shift amount comes from one of two sources. It is either a short count field taken from the instruction, or the low six bits of a count register. A start strobe loads the operands. The unit then steps until the count is used up and reports the new register value, the N, Z, V, C and X flags, and a cycle cost for the operation. A one-cycle done strobe marks the end of each operation. The results stay on the outputs until the next operation is accepted.

Operation codes on `op_i`, with bit 0 giving the direction (0 = left, 1 = right):

| Code | Operation |
| --- | --- |
| 0 | logical shift left |
| 1 | logical shift right |
| 2 | arithmetic shift left |
| 3 | arithmetic shift right |
| 4 | plain rotate left |
| 5 | plain rotate right |
| 6 | rotate left through X |
| 7 | rotate right through X |

Size codes on `size_i`: 0 = byte (bit 7 is the MSB), 1 = word (bit 15), 2 = long (bit 31). Code 3 behaves as long.

Top module: `srot_iter`

## Requirements
- R1: When `cnt_mode_i` is 0, the shift amount is `cnt_field_i`, and a field value of 0 gives an amount of 8.
- R2: When `cnt_mode_i` is 1, the shift amount is `cnt_reg_i` modulo 64, so the amount ranges from 0 to 63.
- R3: Each step of a shift moves one bit. A left shift (codes 0 and 2) puts the old sized MSB into both C and X and inserts 0 at bit 0. A logical right shift (code 1) puts the old bit 0 into both C and X and inserts 0 at the sized MSB.
- R4: An arithmetic right shift (code 3) copies the sized MSB back into itself and puts the old bit 0 into C and X. An arithmetic left shift sets V if the sized MSB changes at any step. For every other operation, V is 0 at the end.
- R5: A plain rotate (codes 4 and 5) feeds the bit that leaves one end back into the other end and copies it into C. X keeps its incoming value.
- R6: A rotate through X (codes 6 and 7) inserts the current X at the vacated end. The bit that leaves goes to C and then becomes the new X.
- R7: With a zero amount, the data word is unchanged. C equals the incoming X for codes 6 and 7 and is 0 for all other codes. X equals the incoming X.
- R8: N is the sized MSB of the result and Z is 1 when the sized result is zero. For byte and word sizes, register bits above the operand size are unchanged.
- R9: `cost_o` is 6 + 2×amount for byte and word sizes and 8 + 2×amount for long.
- R10: The unit does one step per clock. For an amount k, `done_o` is high for exactly one cycle, starting k cycles after the clock edge that accepts `start_i`. `busy_o` is high from acceptance through the done cycle, and a start that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts an operation when the unit is idle |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size code |
| cnt_field_i | input | 3 | Count taken from the instruction field |
| cnt_mode_i | input | 1 | Count source select: 0 = field, 1 = register |
| cnt_reg_i | input | 32 | Count register value |
| data_i | input | 32 | Data register value |
| x_i | input | 1 | Incoming extend flag |
| data_o | output | 32 | Updated data register |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |
| x_o | output | 1 | Extend flag |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cost_o | output | 8 | Cycle cost of the last accepted operation |

## Verification
Two events can land in the same clock. One is the done pulse that ends an operation; the other is a new start strobe. The bench raises `start_i` with different operands during the done cycle, and also partway through the stepping phase. It then checks three things: the finished result and cost are unchanged, `busy_o` and `done_o` fall and stay low, and no second operation begins. Zero-amount operations collapse loading and completion into back-to-back cycles. These are judged on their C and X initial values and on a done latency of zero cycles.

// File: rtl/srot_pkg.sv
package srot_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASL = 3'd2,
    OP_ASR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RXL = 3'd6,
    OP_RXR = 3'd7
  } srot_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_FIN  = 2'd2
  } srot_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  function automatic logic is_rotx(srot_op_e op);
    return (op == OP_RXL) || (op == OP_RXR);
  endfunction

  function automatic logic is_long(logic [1:0] sz);
    return sz[1];
  endfunction
endpackage

// File: rtl/srot_count_dec.sv
module srot_count_dec
  import srot_pkg::*;
#(
  parameter int unsigned FIELD_W    = 3,
  parameter int unsigned AMT_W      = 6,
  parameter int unsigned COST_W     = 8,
  parameter int unsigned BASE_SHORT = 6,
  parameter int unsigned BASE_LONG  = 8
) (
  input  logic [FIELD_W-1:0] field_i,
  input  logic               mode_i,
  input  logic [DATA_W-1:0]  creg_i,
  input  logic [1:0]         size_i,
  output logic [AMT_W-1:0]   amt_o,
  output logic [COST_W-1:0]  cost_o
);
  localparam logic [DATA_W-1:0] REG_MOD   = DATA_W'(1) << AMT_W;
  localparam logic [AMT_W-1:0]  FIELD_MAX = AMT_W'(1) << FIELD_W;

  always_comb begin
    if (mode_i) amt_o = AMT_W'(creg_i % REG_MOD);
    else if (field_i == '0) amt_o = FIELD_MAX;
    else amt_o = AMT_W'(field_i);
    cost_o = (is_long(size_i) ? COST_W'(BASE_LONG) : COST_W'(BASE_SHORT))
           + COST_W'(amt_o) + COST_W'(amt_o);
  end
endmodule

// File: rtl/srot_step.sv
module srot_step
  import srot_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  srot_op_e          op_i,
  input  logic [1:0]        size_i,
  input  logic              x_i,
  output logic [DATA_W-1:0] data_o,
  output logic              out_bit_o,
  output logic              x_o,
  output logic              msb_flip_o
);
  int unsigned       msb;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] sized;
  logic              old_msb;
  logic              ins;

  always_comb begin
    case (size_i)
      SZ_BYTE: begin msb = 7;  mask = DATA_W'(32'h0000_00FF); end
      SZ_WORD: begin msb = 15; mask = DATA_W'(32'h0000_FFFF); end
      default: begin msb = DATA_W - 1; mask = '1; end
    endcase
    old_msb = data_i[msb];
    if (!op_i[0]) begin
      out_bit_o = old_msb;
      case (op_i)
        OP_ROL:  ins = old_msb;
        OP_RXL:  ins = x_i;
        default: ins = 1'b0;
      endcase
      sized = ((data_i << 1) | DATA_W'(ins)) & mask;
    end else begin
      out_bit_o = data_i[0];
      case (op_i)
        OP_ASR:  ins = old_msb;
        OP_ROR:  ins = data_i[0];
        OP_RXR:  ins = x_i;
        default: ins = 1'b0;
      endcase
      sized = ((data_i & mask) >> 1) | (DATA_W'(ins) << msb);
    end
    data_o     = (data_i & ~mask) | sized;
    x_o        = (op_i == OP_ROL || op_i == OP_ROR) ? x_i : out_bit_o;
    msb_flip_o = (op_i == OP_ASL) && (data_o[msb] != old_msb);
  end
endmodule

// File: rtl/srot_nz.sv
module srot_nz
  import srot_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  output logic              n_o,
  output logic              z_o
);
  always_comb begin
    case (size_i)
      SZ_BYTE: begin n_o = data_i[7];  z_o = (data_i[7:0] == '0);  end
      SZ_WORD: begin n_o = data_i[15]; z_o = (data_i[15:0] == '0); end
      default: begin n_o = data_i[DATA_W-1]; z_o = (data_i == '0); end
    endcase
  end
endmodule

// File: rtl/srot_iter.sv
module srot_iter
  import srot_pkg::*;
#(
  parameter int unsigned FIELD_W = 3,
  parameter int unsigned AMT_W   = 6,
  parameter int unsigned COST_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [2:0]         op_i,
  input  logic [1:0]         size_i,
  input  logic [FIELD_W-1:0] cnt_field_i,
  input  logic               cnt_mode_i,
  input  logic [DATA_W-1:0]  cnt_reg_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               x_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               n_o,
  output logic               z_o,
  output logic               v_o,
  output logic               c_o,
  output logic               x_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [COST_W-1:0]  cost_o
);
  srot_state_e       state_q;
  srot_op_e          op_q;
  logic [1:0]        size_q;
  logic [AMT_W-1:0]  rem_q;
  logic [DATA_W-1:0] data_q;
  logic              c_q, x_q, v_q;
  logic [COST_W-1:0] cost_q;

  logic [AMT_W-1:0]  amt;
  logic [COST_W-1:0] cost;
  logic [DATA_W-1:0] step_data;
  logic              step_out, step_x, step_flip;
  srot_op_e          op_in;

  assign op_in = srot_op_e'(op_i);

  srot_count_dec #(
    .FIELD_W(FIELD_W), .AMT_W(AMT_W), .COST_W(COST_W)
  ) u_cnt (
    .field_i(cnt_field_i), .mode_i(cnt_mode_i), .creg_i(cnt_reg_i),
    .size_i(size_i), .amt_o(amt), .cost_o(cost)
  );

  srot_step u_step (
    .data_i(data_q), .op_i(op_q), .size_i(size_q), .x_i(x_q),
    .data_o(step_data), .out_bit_o(step_out), .x_o(step_x), .msb_flip_o(step_flip)
  );

  srot_nz u_nz (.data_i(data_q), .size_i(size_q), .n_o(n_o), .z_o(z_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LSL;
      size_q  <= '0;
      rem_q   <= '0;
      data_q  <= '0;
      c_q     <= 1'b0;
      x_q     <= 1'b0;
      v_q     <= 1'b0;
      cost_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          op_q    <= op_in;
          size_q  <= size_i;
          rem_q   <= amt;
          data_q  <= data_i;
          c_q     <= is_rotx(op_in) ? x_i : 1'b0;
          x_q     <= x_i;
          v_q     <= 1'b0;
          cost_q  <= cost;
          state_q <= (amt == '0) ? ST_FIN : ST_STEP;
        end
        ST_STEP: begin
          data_q <= step_data;
          c_q    <= step_out;
          x_q    <= step_x;
          v_q    <= v_q | step_flip;
          rem_q  <= rem_q - AMT_W'(1);
          if (rem_q == AMT_W'(1)) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o = data_q;
  assign v_o    = v_q;
  assign c_o    = c_q;
  assign x_o    = x_q;
  assign cost_o = cost_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
endmodule

// File: rtl/srot_iter_chk.sv
module srot_iter_chk
  import srot_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [7:0]        cost_o,
  input logic [DATA_W-1:0] data_o,
  input logic              x_o,
  input logic              v_o,
  input srot_op_e          op_q,
  input logic [1:0]        size_q
);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_cost_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cost_o));

  p_rot_x_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (op_q == OP_ROL || op_q == OP_ROR)) |=> $stable(x_o));

  p_upper_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && size_q == SZ_BYTE) |=> $stable(data_o[DATA_W-1:8]));

  p_v_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q != OP_ASL) |-> !v_o);
endmodule

bind srot_iter srot_iter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .cost_o(cost_o), .data_o(data_o), .x_o(x_o), .v_o(v_o),
  .op_q(op_q), .size_q(size_q)
);

// File: tb/srot_iter_bench.sv
module srot_iter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [2:0]  fld = '0;
  logic        md = 1'b0;
  logic [31:0] creg = '0;
  logic [31:0] din = '0;
  logic        xin = 1'b0;
  logic [31:0] dout;
  logic        n, z, v, c, x, busy, done;
  logic [7:0]  cost;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srot_iter u_srot_iter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .size_i(size),
    .cnt_field_i(fld), .cnt_mode_i(md), .cnt_reg_i(creg), .data_i(din), .x_i(xin),
    .data_o(dout), .n_o(n), .z_o(z), .v_o(v), .c_o(c), .x_o(x),
    .busy_o(busy), .done_o(done), .cost_o(cost)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Expected behaviour derived from the requirements
  task automatic model(input logic [2:0] o, input logic [1:0] sz, input logic [2:0] f,
                       input logic m, input logic [31:0] cr, input logic [31:0] d,
                       input logic xi, output logic [31:0] rd, output logic rn,
                       output logic rz, output logic rv, output logic rc,
                       output logic rx, output int k, output int rcost);
    int msb;
    logic [31:0] mask;
    logic ob, om, ins;
    msb  = (sz == 0) ? 7 : (sz == 1) ? 15 : 31;
    mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    k = m ? int'(cr % 64) : ((f == 0) ? 8 : int'(f));
    rd = d; rx = xi; rv = 0;
    rc = (o == 6 || o == 7) ? xi : 1'b0;
    for (int i = 0; i < k; i++) begin
      om = rd[msb];
      if (!o[0]) begin
        ob  = om;
        ins = (o == 4) ? om : (o == 6) ? rx : 1'b0;
        rd  = (rd & ~mask) | (((rd << 1) | {31'b0, ins}) & mask);
      end else begin
        ob  = rd[0];
        ins = (o == 3) ? om : (o == 5) ? rd[0] : (o == 7) ? rx : 1'b0;
        rd  = (rd & ~mask) | ((rd & mask) >> 1);
        rd[msb] = ins;
      end
      rc = ob;
      if (!(o == 4 || o == 5)) rx = ob;
      if (o == 2 && rd[msb] != om) rv = 1;
    end
    rn = rd[msb];
    rz = ((rd & mask) == 0);
    rcost = ((sz >= 2) ? 8 : 6) + 2 * k;
  endtask

  task automatic drive(logic [2:0] o, logic [1:0] sz, logic [2:0] f, logic m,
                       logic [31:0] cr, logic [31:0] d, logic xi);
    op = o; size = sz; fld = f; md = m; creg = cr; din = d; xin = xi;
  endtask

  task automatic run_op(string tag, logic [2:0] o, logic [1:0] sz, logic [2:0] f,
                        logic m, logic [31:0] cr, logic [31:0] d, logic xi);
    logic [31:0] ed;
    logic en, ez, ev, ec, ex;
    int k, ecost, cyc;
    model(o, sz, f, m, cr, d, xi, ed, en, ez, ev, ec, ex, k, ecost);
    @(negedge clk);
    drive(o, sz, f, m, cr, d, xi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " R10 latency"}, cyc, k);
    chk({tag, " data"}, dout, ed);
    chk({tag, " R8 n"}, {31'b0, n}, {31'b0, en});
    chk({tag, " R8 z"}, {31'b0, z}, {31'b0, ez});
    chk({tag, " R4 v"}, {31'b0, v}, {31'b0, ev});
    chk({tag, " c"}, {31'b0, c}, {31'b0, ec});
    chk({tag, " x"}, {31'b0, x}, {31'b0, ex});
    chk({tag, " R9 cost"}, {24'b0, cost}, ecost);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, {31'b0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R10 reset busy", {31'b0, busy}, 32'd0);
    chk("R10 reset done", {31'b0, done}, 32'd0);
    chk("R8 reset data", dout, 32'd0);
    chk("R9 reset cost", {24'b0, cost}, 32'd0);
  endtask

  task automatic t_shifts;
    run_op("R3 lsl byte", 3'd0, 2'd0, 3'd1, 1'b0, 0, 32'hAABB_CC81, 1'b0);
    chk("R8 upper kept", dout, 32'hAABB_CC02);
    run_op("R1 lsr word field0", 3'd1, 2'd1, 3'd0, 1'b0, 0, 32'h1234_F0F1, 1'b0);
    chk("R1 lsr by 8", dout, 32'h1234_00F0);
    run_op("R3 lsl long", 3'd0, 2'd2, 3'd3, 1'b0, 0, 32'hE000_0001, 1'b0);
    run_op("R3 lsr long max", 3'd1, 2'd2, 3'd0, 1'b1, 32'd63, 32'h8000_0000, 1'b0);
    chk("R9 cost 63", {24'b0, cost}, 32'd134);
  endtask

  task automatic t_arith;
    run_op("R4 asl flip", 3'd2, 2'd0, 3'd1, 1'b0, 0, 32'h0000_0040, 1'b0);
    chk("R4 asl v set", {31'b0, v}, 32'd1);
    run_op("R4 asl sticky", 3'd2, 2'd0, 3'd3, 1'b0, 0, 32'h0000_0030, 1'b1);
    run_op("R4 asl no flip", 3'd2, 2'd0, 3'd1, 1'b0, 0, 32'h0000_00C0, 1'b0);
    chk("R4 asl v clear", {31'b0, v}, 32'd0);
    run_op("R4 asr word", 3'd3, 2'd1, 3'd3, 1'b0, 0, 32'h5555_8005, 1'b0);
    chk("R4 asr sign", dout, 32'h5555_F000);
  endtask

  task automatic t_rot;
    run_op("R5 ror byte", 3'd5, 2'd0, 3'd1, 1'b0, 0, 32'h0000_0001, 1'b0);
    chk("R5 ror wrap", dout, 32'h0000_0080);
    run_op("R2 rol long reg", 3'd4, 2'd2, 3'd0, 1'b1, 32'hFFFF_FF45, 32'h8765_4321, 1'b1);
    run_op("R6 rxl long", 3'd6, 2'd2, 3'd1, 1'b0, 0, 32'h8000_0000, 1'b1);
    chk("R6 rxl x in", dout, 32'h0000_0001);
    run_op("R6 rxr word reg", 3'd7, 2'd1, 3'd0, 1'b1, 32'd17, 32'hDEAD_0003, 1'b0);
    run_op("R6 rxl byte", 3'd6, 2'd0, 3'd5, 1'b0, 0, 32'h1111_11A5, 1'b1);
  endtask

  task automatic t_zero;
    run_op("R7 rxl zero", 3'd6, 2'd0, 3'd0, 1'b1, 32'd64, 32'h0000_0055, 1'b1);
    chk("R7 rxl c=x", {31'b0, c}, 32'd1);
    run_op("R7 lsl zero", 3'd0, 2'd2, 3'd0, 1'b1, 32'd128, 32'h0000_0000, 1'b1);
    chk("R7 lsl c=0", {31'b0, c}, 32'd0);
    chk("R7 lsl x kept", {31'b0, x}, 32'd1);
  endtask

  task automatic t_overlap;
    logic [31:0] ed;
    logic en, ez, ev, ec, ex;
    int k, ecost;
    model(3'd1, 2'd2, 3'd4, 1'b0, 0, 32'hF0F0_0000, 1'b0, ed, en, ez, ev, ec, ex, k, ecost);
    @(negedge clk);
    drive(3'd1, 2'd2, 3'd4, 1'b0, 0, 32'hF0F0_0000, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    drive(3'd0, 2'd0, 3'd1, 1'b0, 0, 32'h1234_5678, 1'b1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    chk("R10 busy start ignored data", dout, ed);
    chk("R10 busy start ignored cost", {24'b0, cost}, ecost);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done-cycle start busy", {31'b0, busy}, 32'd0);
    chk("R10 done-cycle start done", {31'b0, done}, 32'd0);
    chk("R10 done-cycle start data", dout, ed);
    @(negedge clk);
    chk("R10 no second op", {31'b0, busy}, 32'd0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog R10 act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_shifts();
    t_arith();
    t_rot();
    t_zero();
    t_overlap();
    finish_run();
  end
endmodule